// File: doc/BRIEF.md
# Prescaled Timer/Counter with Watchdog Prescaler Sharing

This block is an 8-bit up-counter for a small controller. It counts one of two sources. The first is the instruction-cycle enable. The second is edges on an external pin. Pin edges are caught by a two-stage synchronizer followed by a rising/falling edge selector.

An 8-bit prescaler divides the count by a power of two from 2 to 256. One control bit hands this prescaler either to the counter or to a watchdog time base. When the prescaler is handed to the watchdog, the counter takes every qualified event directly and the prescaler divides the watchdog ticks instead.

Software can read and write the counter. A write holds counting off for the next two instruction cycles. A wrap from FFh to 00h sets a sticky flag, and an enable bit gates that flag onto the interrupt line. A global stop input freezes the counter while the processor sleeps.

Top module: `tmr_core_top`

## Requirements
- R1: After reset, rd_data is 00h and ovf_flag and irq are 0.
- R2: With src_ext=0 and pre_to_wdt=1, the counter advances by one on every clock edge at which cyc_en is 1, and holds otherwise.
- R3: With src_ext=1, a change of ext_in sampled at clock edge k is counted at edge k+2. Only rising changes count when edge_fall=0, and only falling changes when edge_fall=1. cyc_en does not gate pin counting.
- R4: With pre_to_wdt=0, the counter advances once per 2^(ratio_sel+1) qualified source events. So 000 is 1:2 and 111 is 1:256.
- R5: A write (wr_en=1) loads wr_data at that edge and clears the prescaler count. No increment then happens at the next two clock edges at which cyc_en is 1.
- R6: An increment from FFh gives 00h and sets ovf_flag. The flag stays set until flag_clr=1. If a clear and an overflow fall on the same edge, the flag stays set.
- R7: irq is 1 exactly when ovf_flag and irq_en are both 1.
- R8: While halt=1, the counter neither advances nor overflows, and qualified events are dropped.
- R9: With pre_to_wdt=1, wdt_tick is 1 in the cycle of every 2^(ratio_sel+1)-th wdt_src pulse (halt has no effect). With pre_to_wdt=0, wdt_tick stays 0.
- R10: A write wins over an increment on the same edge, and a write never sets ovf_flag, even when the value loaded is 00h or FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cyc_en | input | 1 | Instruction-cycle enable |
| ext_in | input | 1 | External count pin |
| halt | input | 1 | Global stop (sleep) |
| wdt_src | input | 1 | Watchdog time-base pulse |
| src_ext | input | 1 | 0: count cyc_en, 1: count pin edges |
| edge_fall | input | 1 | 0: rising pin edges, 1: falling pin edges |
| pre_to_wdt | input | 1 | 0: prescaler on counter, 1: prescaler on watchdog |
| ratio_sel | input | 3 | Prescale ratio 2^(n+1) |
| irq_en | input | 1 | Interrupt enable |
| wr_en | input | 1 | Counter write strobe |
| wr_data | input | 8 | Counter write value |
| flag_clr | input | 1 | Clear overflow flag |
| rd_data | output | 8 | Counter value |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Masked interrupt |
| wdt_tick | output | 1 | Prescaled watchdog tick |

## Verification
A wrong prescaler count or a wrong write-hold count shows up as rd_data stepping one edge early or late. This appears at the first increment after the fault, at most 256 source events later. A fault in the synchronizer or the edge selector moves every pin increment by a whole cycle, or counts the wrong polarity, and is visible at the next counted edge. A fault in the sticky flag appears on ovf_flag and irq in the cycle after the wrap or the clear. The reference model is compared against the ports on every clock, so each of these faults is flagged within the cycle it first becomes visible.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned CNT_W_DEF  = 8;
  localparam int unsigned PRE_W_DEF  = 8;
  localparam int unsigned SEL_W_DEF  = 3;
  localparam int unsigned SYNC_DEF   = 2;
  localparam int unsigned HOLD_DEF   = 2;

  typedef enum logic {
    SRC_CYCLE = 1'b0,
    SRC_PIN   = 1'b1
  } src_e;

  typedef enum logic {
    PRE_ON_CNT = 1'b0,
    PRE_ON_WDT = 1'b1
  } pre_own_e;
endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [DEPTH-1:0] chain_q;
  logic [DEPTH-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[DEPTH-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[DEPTH-1];
endmodule

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic fall_sel,
  output logic evt
);
  localparam int unsigned LEN = STAGES + 1;

  logic [LEN-1:0] lvl_q;
  logic [LEN-1:0] lvl_d;

  always_comb lvl_d[0] = pin;

  for (genvar i = 1; i < LEN; i++) begin : g_stage
    always_comb lvl_d[i] = lvl_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl_d;
  end

  logic cur_lvl, old_lvl;
  assign cur_lvl = lvl_q[STAGES-1];
  assign old_lvl = lvl_q[STAGES];

  always_comb begin
    if (fall_sel) evt = old_lvl & ~cur_lvl;
    else          evt = ~old_lvl & cur_lvl;
  end
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned PRE_W = 8,
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  input  logic [SEL_W-1:0] sel,
  output logic             carry
);
  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] cnt_d;
  logic [PRE_W:0]   span;
  logic [PRE_W-1:0] mask;

  always_comb begin
    span = (PRE_W+1)'(1) << (32'(sel) + 32'd1);
    mask = PRE_W'(span - (PRE_W+1)'(1));
  end

  assign carry = adv & ((cnt_q & mask) == mask);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (adv) cnt_d = cnt_q + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned HOLD_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_en,
  input  logic             halt,
  input  logic             inc,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] cnt,
  output logic             flag,
  output logic             blocked
);
  localparam int unsigned HOLD_W = $clog2(HOLD_CYC + 1);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [HOLD_W-1:0] hold_q, hold_d;
  logic              flag_q, flag_d;
  logic              wrap;

  assign blocked = (hold_q != '0);

  always_comb begin
    cnt_d  = cnt_q;
    hold_d = hold_q;
    wrap   = 1'b0;
    if (wr_en) begin
      cnt_d  = wr_data;
      hold_d = HOLD_W'(HOLD_CYC);
    end else begin
      if (blocked && cyc_en) hold_d = hold_q - HOLD_W'(1);
      if (inc) begin
        cnt_d = cnt_q + CNT_W'(1);
        wrap  = (cnt_q == TOP);
      end
    end
  end

  always_comb begin
    flag_d = flag_q;
    if (wrap)          flag_d = 1'b1;
    else if (flag_clr) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      hold_q <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      hold_q <= hold_d;
      flag_q <= flag_d;
    end
  end

  assign cnt  = cnt_q;
  assign flag = flag_q;

  // R5
  wr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (cnt_q == $past(wr_data)));

  // R5
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !inc);

  // R6
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !wr_en && cnt_q == TOP) |=> (flag_q && cnt_q == '0));

  // R6
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_clr) |=> flag_q);

  // R8
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !wr_en) |=> $stable(cnt_q));
endmodule

// File: rtl/tmr_core_top.sv
module tmr_core_top
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W       = CNT_W_DEF,
  parameter int unsigned PRE_W       = PRE_W_DEF,
  parameter int unsigned SEL_W       = SEL_W_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_DEF,
  parameter int unsigned HOLD_CYC    = HOLD_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_en,
  input  logic             ext_in,
  input  logic             halt,
  input  logic             wdt_src,
  input  logic             src_ext,
  input  logic             edge_fall,
  input  logic             pre_to_wdt,
  input  logic [SEL_W-1:0] ratio_sel,
  input  logic             irq_en,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] rd_data,
  output logic             ovf_flag,
  output logic             irq,
  output logic             wdt_tick
);
  logic rst_n_i;
  logic pin_evt;
  logic src_evt;
  logic gate_evt;
  logic pre_adv;
  logic pre_carry;
  logic cnt_inc;
  logic blocked;
  src_e     src_mode;
  pre_own_e pre_own;

  assign src_mode = src_e'(src_ext);
  assign pre_own  = pre_own_e'(pre_to_wdt);

  tmr_rst_sync #(.DEPTH(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .pin      (ext_in),
    .fall_sel (edge_fall),
    .evt      (pin_evt)
  );

  always_comb begin
    src_evt  = (src_mode == SRC_PIN) ? pin_evt : cyc_en;
    gate_evt = src_evt & ~halt & ~blocked;
    if (pre_own == PRE_ON_WDT) begin
      pre_adv  = wdt_src;
      cnt_inc  = gate_evt;
      wdt_tick = pre_carry;
    end else begin
      pre_adv  = gate_evt;
      cnt_inc  = pre_carry;
      wdt_tick = 1'b0;
    end
  end

  tmr_prescaler #(.PRE_W(PRE_W), .SEL_W(SEL_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_n_i),
    .clr   (wr_en),
    .adv   (pre_adv),
    .sel   (ratio_sel),
    .carry (pre_carry)
  );

  tmr_count_core #(.CNT_W(CNT_W), .HOLD_CYC(HOLD_CYC)) u_core (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .cyc_en   (cyc_en),
    .halt     (halt),
    .inc      (cnt_inc),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .flag_clr (flag_clr),
    .cnt      (rd_data),
    .flag     (ovf_flag),
    .blocked  (blocked)
  );

  assign irq = ovf_flag & irq_en;

  // R9
  wdt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (pre_own == PRE_ON_CNT) |-> !wdt_tick);
endmodule

// File: tb/tmr_core_top_tb.sv
module tmr_core_top_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cyc_en, ext_in, halt, wdt_src, src_ext, edge_fall, pre_to_wdt;
  logic [2:0] ratio_sel;
  logic       irq_en, wr_en, flag_clr;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       ovf_flag, irq, wdt_tick;

  always #5 clk = ~clk;

  tmr_core_top u_dut (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .ext_in(ext_in), .halt(halt),
    .wdt_src(wdt_src), .src_ext(src_ext), .edge_fall(edge_fall),
    .pre_to_wdt(pre_to_wdt), .ratio_sel(ratio_sel), .irq_en(irq_en),
    .wr_en(wr_en), .wr_data(wr_data), .flag_clr(flag_clr),
    .rd_data(rd_data), .ovf_flag(ovf_flag), .irq(irq), .wdt_tick(wdt_tick)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  // reference model state
  int m_cnt = 0;
  int m_pre = 0;
  int m_hold = 0;
  bit m_flag = 1'b0;
  bit hist[$] = '{1'b0, 1'b0, 1'b0, 1'b0};

  function automatic int span_of(input logic [2:0] s);
    return 1 << (int'(s) + 1);
  endfunction

  always @(posedge clk) begin
    if (rst_n) begin
      bit nl, ol, pev, src, gate, adv, carry, inc, wrap;
      int n;
      nl   = hist[hist.size()-2];
      ol   = hist[hist.size()-3];
      pev  = edge_fall ? (ol && !nl) : (!ol && nl);
      src  = src_ext ? pev : cyc_en;
      gate = src && !halt && (m_hold == 0);
      n    = span_of(ratio_sel);
      adv  = pre_to_wdt ? wdt_src : gate;
      carry = adv && ((m_pre % n) == n - 1);
      inc  = pre_to_wdt ? gate : carry;
      wrap = 1'b0;
      if (wr_en) begin
        m_cnt  = int'(wr_data);
        m_pre  = 0;
        m_hold = 2;
      end else begin
        if (m_hold > 0 && cyc_en) m_hold = m_hold - 1;
        if (adv) m_pre = (m_pre + 1) % 256;
        if (inc) begin
          if (m_cnt == 255) begin m_cnt = 0; wrap = 1'b1; end
          else m_cnt = m_cnt + 1;
        end
      end
      if (wrap) m_flag = 1'b1;
      else if (flag_clr) m_flag = 1'b0;
      hist.push_back(ext_in);
      if (hist.size() > 8) void'(hist.pop_front());
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      bit e_tick;
      int n;
      #4;
      n = span_of(ratio_sel);
      e_tick = rst_n && pre_to_wdt && wdt_src && ((m_pre % n) == n - 1);
      n_cmp++;
      if (rd_data !== 8'(m_cnt)) begin
        n_bad++;
        $display("FAIL %s rd_data act %h exp %h t=%0t", cur_req, rd_data, 8'(m_cnt), $time);
      end
      n_cmp++;
      if (ovf_flag !== m_flag) begin
        n_bad++;
        $display("FAIL %s ovf_flag act %b exp %b t=%0t", cur_req, ovf_flag, m_flag, $time);
      end
      n_cmp++;
      if (irq !== (m_flag && irq_en)) begin
        n_bad++;
        $display("FAIL %s irq act %b exp %b t=%0t", cur_req, irq, m_flag && irq_en, $time);
      end
      n_cmp++;
      if (wdt_tick !== e_tick) begin
        n_bad++;
        $display("FAIL %s wdt_tick act %b exp %b t=%0t", cur_req, wdt_tick, e_tick, $time);
      end
    end
  end

  task automatic run(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic write(input logic [7:0] v);
    wr_en = 1'b1; wr_data = v;
    run(1);
    wr_en = 1'b0;
  endtask

  task automatic finish_up();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog expired in %s", cur_req);
    finish_up();
  end

  initial begin
    rst_n = 1'b0; cyc_en = 1'b0; ext_in = 1'b0; halt = 1'b0; wdt_src = 1'b0;
    src_ext = 1'b0; edge_fall = 1'b0; pre_to_wdt = 1'b1; ratio_sel = 3'd0;
    irq_en = 1'b0; wr_en = 1'b0; wr_data = 8'h00; flag_clr = 1'b0;
    cur_req = "R1";
    run(3);
    rst_n = 1'b1;
    run(5);

    cur_req = "R2";
    cyc_en = 1'b1;
    run(20);
    for (int i = 0; i < 20; i++) begin
      cyc_en = i[0];
      run(1);
    end
    cyc_en = 1'b1;

    cur_req = "R3";
    src_ext = 1'b1; edge_fall = 1'b0;
    for (int i = 0; i < 12; i++) begin
      ext_in = ~ext_in;
      run(3);
    end
    edge_fall = 1'b1; cyc_en = 1'b0;
    for (int i = 0; i < 12; i++) begin
      ext_in = ~ext_in;
      run(2 + (i % 3));
    end
    cyc_en = 1'b1; src_ext = 1'b0; ext_in = 1'b0;
    run(4);

    cur_req = "R4";
    pre_to_wdt = 1'b0;
    for (int r = 0; r < 4; r++) begin
      ratio_sel = 3'(r);
      run(40);
    end
    ratio_sel = 3'd7;
    write(8'h10);
    run(600);

    cur_req = "R5";
    ratio_sel = 3'd2;
    run(5);
    write(8'h40);
    run(12);
    pre_to_wdt = 1'b1;
    write(8'h80);
    run(3);
    cyc_en = 1'b0; run(3); cyc_en = 1'b1;
    run(4);

    cur_req = "R10";
    write(8'hFF);
    write(8'h00);
    run(2);
    write(8'hFF);
    run(6);

    cur_req = "R6";
    irq_en = 1'b1;
    flag_clr = 1'b1; run(1); flag_clr = 1'b0;
    write(8'hFD);
    run(8);
    write(8'hFF);
    flag_clr = 1'b1;
    run(6);
    flag_clr = 1'b0;

    cur_req = "R7";
    write(8'hFE);
    run(6);
    irq_en = 1'b0; run(3);
    irq_en = 1'b1; run(3);
    flag_clr = 1'b1; run(1); flag_clr = 1'b0;
    run(2);

    cur_req = "R8";
    write(8'hFC);
    run(4);
    halt = 1'b1;
    run(10);
    halt = 1'b0;
    run(6);
    pre_to_wdt = 1'b0; ratio_sel = 3'd0;
    halt = 1'b1; run(8); halt = 1'b0; run(6);

    cur_req = "R9";
    pre_to_wdt = 1'b1; ratio_sel = 3'd0;
    wdt_src = 1'b1; run(10);
    ratio_sel = 3'd2;
    for (int i = 0; i < 24; i++) begin
      wdt_src = i[0];
      halt = i[2];
      run(1);
    end
    halt = 1'b0; wdt_src = 1'b0;
    pre_to_wdt = 1'b0;
    wdt_src = 1'b1; run(10); wdt_src = 1'b0;

    cur_req = "R10 mixed";
    for (int i = 0; i < 2500; i++) begin
      cyc_en     = ($urandom % 4) != 0;
      ext_in     = ($urandom % 3) == 0;
      halt       = ($urandom % 16) == 0;
      wdt_src    = $urandom % 2;
      src_ext    = (i / 400) % 2;
      edge_fall  = (i / 800) % 2;
      pre_to_wdt = (i / 300) % 2;
      ratio_sel  = 3'((i / 600) % 3);
      irq_en     = $urandom % 2;
      flag_clr   = ($urandom % 20) == 0;
      wr_en      = ($urandom % 40) == 0;
      wr_data    = 8'($urandom % 256) | 8'hF0;
      run(1);
    end
    wr_en = 1'b0; flag_clr = 1'b0;
    run(3);
    finish_up();
  end
endmodule